// File: doc/BRIEF.md
# Programmable Wait-State Acknowledge Generator

This block produces the CPU-side handshake for the access port of a dynamic RAM controller. When a chip-selected access begins, the controller raises a one-cycle strobe on the clock edge at which the row strobe is launched. From that edge the block counts a programmed number of rising clock edges. It can then optionally wait for the following clock-low phase before it signals that the data transfer can complete. The output can act as an active-low acknowledge, which rests negated and asserts when the delay is over. It can instead act as an active-low wait line, which is asserted from the start of the access until the delay is over.

A per-access extension input lengthens the rising-edge count by one or two edges, and a programming bit selects which. The extension is sampled on the edge at which the base count would otherwise finish. The extra edges are always counted before the optional low-phase half cycle. For page bursts, the acknowledge can be re-armed by the column-enable input. When that input goes negated during an acknowledged access, the handshake drops. When it asserts again, the full delay runs again from that edge. Ending the request closes the access, and the output stays inactive until a new access starts.

The programming bits are captured only while reset is held, on a load strobe, so the timing cannot change in the middle of operation.

Top module: `wsack_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `hs_n` is 1, the access state is idle and the edge count is cleared. This holds in both output modes.
- R2: The programming inputs are captured only on a rising edge where both `rst` and `cfg_load` are 1. A `cfg_load` pulse with `rst` low leaves the programmed delay unchanged.
- R3: In acknowledge mode (`cfg_ack_mode`=1, `cfg_half_en`=0), the start edge is edge 0: the first rising edge that samples `acc_req`=1 and `ras_start`=1 while idle. `hs_n` goes to 0 right after rising edge number N, where N = `cfg_base` (0..2^BASE_W-1).
- R4: With `cfg_half_en`=1, `hs_n` asserts at the falling clock edge that follows rising edge N instead. It still negates right after a rising edge.
- R5: If `wait_ext`=1 on rising edge number `cfg_base`, N grows by 1 (`cfg_ext_two`=0) or by 2 (`cfg_ext_two`=1). The half-cycle low phase of R4 comes after these extra edges.
- R6: Changing `wait_ext` after `hs_n` has asserted has no effect on the current access.
- R7: A rising edge that samples `acc_req`=0 ends the access, and `hs_n` is inactive right after it. `hs_n` stays inactive until a new start edge. A `ras_start` pulse with `acc_req`=0, or `acc_req`=1 without `ras_start`, does not start an access.
- R8: With `cfg_burst_en`=1, suppose a rising edge samples `cas_en_n`=1 while the access is acknowledged and `acc_req`=1. Then `hs_n` negates right after that edge. The next rising edge that samples `cas_en_n`=0 becomes a new edge 0, and the R3 to R5 delay runs again from it.
- R9: With `cfg_burst_en`=0, `cas_en_n` toggles during an acknowledged access leave `hs_n` asserted.
- R10: In wait mode (`cfg_ack_mode`=0), `hs_n` is 0 from right after the start edge until the moment the acknowledge of R3 to R5 would assert, and 1 otherwise. With N=0 it never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Captures the programming inputs while `rst` is high |
| cfg_ack_mode | input | 1 | 1: acknowledge output, 0: wait output |
| cfg_burst_en | input | 1 | Enables the page-burst re-handshake |
| cfg_half_en | input | 1 | Adds the trailing clock-low half cycle |
| cfg_ext_two | input | 1 | Extension adds two edges (1) or one (0) |
| cfg_base | input | BASE_W | Base rising-edge count |
| acc_req | input | 1 | Access request, active high |
| ras_start | input | 1 | One-cycle strobe on the row-strobe launch edge |
| cas_en_n | input | 1 | Column enable, active low |
| wait_ext | input | 1 | Per-access wait extension request |
| hs_n | output | 1 | Active-low acknowledge or wait handshake |

## Verification
The bound checker watches several rules on every clock edge. The output is inactive after reset. The programming stays stable outside reset. An asserted acknowledge always follows a live request, and it drops on the edge after the request ends. It stays asserted while the column enable is held, or whenever bursts are disabled, whatever the extension input does. It drops when the column enable negates during a burst. Other behaviour can only be shown by the bench scenarios, which count the exact edges of each delay. These cover the base count for several settings, the one-edge and two-edge extension, the half-cycle falling-edge placement observed between clock edges, the restart of the count from a column-enable edge, and the wait-mode waveform.

// File: rtl/wsack_pkg.sv
package wsack_pkg;

   // Largest number of edges the extension input may add
   localparam int unsigned WSACK_EXT_MAX = 2;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COUNT   = 2'd1,
      ST_ACKED   = 2'd2,
      ST_CAS_OFF = 2'd3
   } wsack_state_e;

   typedef struct packed {
      logic ack_mode;
      logic burst_en;
      logic half_en;
      logic ext_two;
   } wsack_flags_t;

endpackage

// File: rtl/wsack_cfg_reg.sv
module wsack_cfg_reg #(
   parameter int BASE_W = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  wsack_pkg::wsack_flags_t flags_in,
   input  logic [BASE_W-1:0]       base_in,
   output wsack_pkg::wsack_flags_t flags_q,
   output logic [BASE_W-1:0]       base_q
);

   // Programming is only accepted while the block is held in reset
   always_ff @(posedge clk) begin
      if (rst && load) begin
         flags_q <= flags_in;
         base_q  <= base_in;
      end
   end

endmodule

// File: rtl/wsack_edge_counter.sv
module wsack_edge_counter #(
   parameter int BASE_W = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              run,
   input  logic [BASE_W-1:0] base,
   input  logic              ext_two,
   input  logic              wait_ext,
   output logic              hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target_q;
   logic             ext_q;

   logic [CNT_W-1:0] k;
   logic [CNT_W-1:0] base_x;
   logic [CNT_W-1:0] ext_n;
   logic             ext_eff;
   logic             ext_now;
   logic             active;

   assign active  = start | run;
   assign base_x  = CNT_W'(base);
   assign ext_n   = ext_two ? CNT_W'(2) : CNT_W'(1);
   // Edge index of the current rising edge: the start edge is edge 0
   assign k       = start ? '0 : cnt_q + CNT_W'(1);
   assign ext_eff = ext_q & ~start;
   // Extension is sampled on the edge where the base count completes
   assign ext_now = ~ext_eff & (k == base_x) & wait_ext;
   assign hit     = active & (ext_eff ? (k == target_q)
                                      : ((k == base_x) & ~wait_ext));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         target_q <= '0;
         ext_q    <= 1'b0;
      end else if (active) begin
         cnt_q <= k;
         ext_q <= ext_eff | ext_now;
         if (ext_now) begin
            target_q <= base_x + ext_n;
         end
      end
   end

endmodule

// File: rtl/wsack_half_stage.sv
module wsack_half_stage #(
   parameter bit HALF_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic half_en,
   input  logic done,
   output logic lvl
);

   generate
      if (HALF_SUPPORT) begin : g_half
         logic done_neg;
         // Falling-edge copy: the level rises only in the clock-low phase
         always_ff @(negedge clk) begin
            if (rst) begin
               done_neg <= 1'b0;
            end else begin
               done_neg <= done;
            end
         end
         // Both terms are registers, so negation follows the rising edge
         assign lvl = half_en ? (done & done_neg) : done;
      end else begin : g_full
         logic unused_half;
         assign unused_half = half_en ^ rst;
         assign lvl = done;
      end
   endgenerate

endmodule

// File: rtl/wsack_gen.sv
module wsack_gen #(
   parameter int BASE_W       = 2,
   parameter bit HALF_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_load,
   input  logic              cfg_ack_mode,
   input  logic              cfg_burst_en,
   input  logic              cfg_half_en,
   input  logic              cfg_ext_two,
   input  logic [BASE_W-1:0] cfg_base,
   input  logic              acc_req,
   input  logic              ras_start,
   input  logic              cas_en_n,
   input  logic              wait_ext,
   output logic              hs_n
);
   import wsack_pkg::*;

   localparam int MAX_EDGES = (1 << BASE_W) - 1 + WSACK_EXT_MAX;
   localparam int CNT_W     = $clog2(MAX_EDGES + 1);

   generate
      if (BASE_W < 1 || BASE_W > 4) begin : g_bad_base
         $error("wsack_gen: BASE_W must be within 1..4");
      end
   endgenerate

   wsack_flags_t      flags_in;
   wsack_flags_t      flags_q;
   logic [BASE_W-1:0] base_q;

   assign flags_in = '{ack_mode: cfg_ack_mode, burst_en: cfg_burst_en,
                       half_en: cfg_half_en, ext_two: cfg_ext_two};

   wsack_cfg_reg #(.BASE_W(BASE_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .load     (cfg_load),
      .flags_in (flags_in),
      .base_in  (cfg_base),
      .flags_q  (flags_q),
      .base_q   (base_q)
   );

   wsack_state_e state_q, state_d;
   logic         cnt_start;
   logic         cnt_run;
   logic         hit;

   wsack_edge_counter #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .start    (cnt_start),
      .run      (cnt_run),
      .base     (base_q),
      .ext_two  (flags_q.ext_two),
      .wait_ext (wait_ext),
      .hit      (hit)
   );

   always_comb begin
      state_d   = state_q;
      cnt_start = 1'b0;
      cnt_run   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (acc_req && ras_start) begin
               cnt_start = 1'b1;
               state_d   = hit ? ST_ACKED : ST_COUNT;
            end
         end
         ST_COUNT: begin
            if (!acc_req) begin
               state_d = ST_IDLE;
            end else begin
               cnt_run = 1'b1;
               if (hit) state_d = ST_ACKED;
            end
         end
         ST_ACKED: begin
            if (!acc_req) begin
               state_d = ST_IDLE;
            end else if (flags_q.burst_en && cas_en_n) begin
               state_d = ST_CAS_OFF;
            end
         end
         ST_CAS_OFF: begin
            if (!acc_req) begin
               state_d = ST_IDLE;
            end else if (!cas_en_n) begin
               // Column enable toggled back: restart the delay from here
               cnt_start = 1'b1;
               state_d   = hit ? ST_ACKED : ST_COUNT;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   logic done;
   logic busy;
   logic ack_lvl;

   assign done = (state_q == ST_ACKED);
   assign busy = (state_q != ST_IDLE);

   wsack_half_stage #(.HALF_SUPPORT(HALF_SUPPORT)) u_half (
      .clk     (clk),
      .rst     (rst),
      .half_en (flags_q.half_en),
      .done    (done),
      .lvl     (ack_lvl)
   );

   assign hs_n = flags_q.ack_mode ? ~ack_lvl : ~(busy & ~ack_lvl);

endmodule

// File: rtl/wsack_checker.sv
module wsack_checker #(
   parameter int BASE_W = 2
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    acc_req,
   input logic                    cas_en_n,
   input logic                    hs_n,
   input wsack_pkg::wsack_flags_t flags,
   input logic [BASE_W-1:0]       base
);

   // R1: output inactive on the cycle following a reset edge
   assert_reset_negated_R1: assert property (@(posedge clk)
      $past(rst) |-> hs_n);

   // R2: programming cannot move outside reset
   assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ($stable(flags) && $stable(base)));

   // R7: an asserted acknowledge always follows a live request
   assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
      (flags.ack_mode && !hs_n) |-> $past(acc_req));

   // R7: dropping the request negates the acknowledge on the next edge
   assert_end_negates_R7: assert property (@(posedge clk) disable iff (rst)
      (flags.ack_mode && !acc_req) |=> hs_n);

   // R9 and R6: acknowledge holds while the request stays and no burst drop applies
   assert_ack_holds_R9: assert property (@(posedge clk) disable iff (rst)
      (flags.ack_mode && !hs_n && acc_req && !(flags.burst_en && cas_en_n))
      |=> !hs_n);

   // R8: column enable negating in a burst drops the acknowledge
   assert_burst_drop_R8: assert property (@(posedge clk) disable iff (rst)
      (flags.ack_mode && flags.burst_en && !hs_n && acc_req && cas_en_n)
      |=> hs_n);

endmodule

bind wsack_gen wsack_checker #(.BASE_W(BASE_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .acc_req  (acc_req),
   .cas_en_n (cas_en_n),
   .hs_n     (hs_n),
   .flags    (flags_q),
   .base     (base_q)
);

// File: tb/wsack_gen_bench.sv
`timescale 1ns/1ps
module wsack_gen_bench;

   localparam int BASE_W = 2;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cfg_load = 1'b0;
   logic              cfg_ack_mode = 1'b1;
   logic              cfg_burst_en = 1'b0;
   logic              cfg_half_en = 1'b0;
   logic              cfg_ext_two = 1'b0;
   logic [BASE_W-1:0] cfg_base = '0;
   logic              acc_req = 1'b0;
   logic              ras_start = 1'b0;
   logic              cas_en_n = 1'b1;
   logic              wait_ext = 1'b0;
   logic              hs_n;

   always #4 clk = ~clk;

   wsack_gen #(.BASE_W(BASE_W)) u_wsack_gen (
      .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_ack_mode(cfg_ack_mode),
      .cfg_burst_en(cfg_burst_en), .cfg_half_en(cfg_half_en),
      .cfg_ext_two(cfg_ext_two), .cfg_base(cfg_base), .acc_req(acc_req),
      .ras_start(ras_start), .cas_en_n(cas_en_n), .wait_ext(wait_ext),
      .hs_n(hs_n)
   );

   typedef struct {
      int    cyc;
      logic  e;
      logic  l;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   ack_m = 1'b1;

   task automatic check(input logic act, input logic exp, input string tag,
                        input string ph);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s, cycle %0d): hs_n=%b expected %b", tag, ph, cyc, act, exp);
      end
   endtask

   // Monitor: early sample before the falling edge, late sample after it
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (q.size() > 0 && q[0].cyc == cyc) begin
            exp_t it;
            it = q.pop_front();
            #3 check(hs_n, it.e, it.tag, "early");
            #4 check(hs_n, it.l, it.tag, "late");
         end
      end
   end

   function automatic logic hsv(input bit busy, input bit rdy);
      return ack_m ? !rdy : !(busy && !rdy);
   endfunction

   // Drive one cycle of inputs and push the output expected after that edge
   task automatic drive(input logic req, input logic ras, input logic casn,
                        input logic wext, input logic ee, input logic el,
                        input string tag);
      exp_t it;
      @(posedge clk);
      #1;
      acc_req = req; ras_start = ras; cas_en_n = casn; wait_ext = wext;
      it.cyc = cyc + 1; it.e = ee; it.l = el; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic configure(input bit am, input bit be, input bit he,
                            input bit two, input int b);
      @(posedge clk);
      #1;
      rst = 1'b1; cfg_load = 1'b1; acc_req = 1'b0; ras_start = 1'b0;
      cas_en_n = 1'b1; wait_ext = 1'b0;
      cfg_ack_mode = am; cfg_burst_en = be; cfg_half_en = he;
      cfg_ext_two = two; cfg_base = BASE_W'(b);
      ack_m = am;
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R1 in reset");
      cfg_load = 1'b0;
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R1 in reset");
      rst = 1'b0;
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R1 after reset");
   endtask

   // One access: delay n edges, held `hold` cycles past n, then ended
   task automatic access(input int n, input bit half, input logic w0,
                         input logic wlate, input int hold, input string tag);
      for (int j = 0; j <= n + hold; j++) begin
         bit re;
         bit rl;
         re = half ? (j >= n + 1) : (j >= n);
         rl = (j >= n);
         drive(1'b1, (j == 0), 1'b0, (j > n) ? wlate : w0,
               hsv(1'b1, re), hsv(1'b1, rl), tag);
      end
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 end of access");
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 idle");
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R3 base count, R5 single-edge extension
      configure(1'b1, 1'b0, 1'b0, 1'b0, 2);
      access(2, 1'b0, 1'b0, 1'b0, 2, "R3 base 2");
      access(3, 1'b0, 1'b1, 1'b1, 1, "R5 extension one edge");
      // R7: lone strobe or request without strobe starts nothing
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 strobe without request");
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7 request without strobe");
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7 request without strobe");
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 idle");

      // R4 half cycle, R5 two-edge extension placed before the low phase
      configure(1'b1, 1'b0, 1'b1, 1'b1, 1);
      access(3, 1'b1, 1'b1, 1'b1, 2, "R5 R4 extension two edges then half");
      access(1, 1'b1, 1'b0, 1'b0, 2, "R4 half cycle base 1");

      // R3 base zero
      configure(1'b1, 1'b0, 1'b0, 1'b0, 0);
      access(0, 1'b0, 1'b0, 1'b0, 2, "R3 base 0");

      // R2: load outside reset is ignored
      configure(1'b1, 1'b0, 1'b0, 1'b0, 3);
      cfg_base = BASE_W'(0); cfg_load = 1'b1;
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R2 load outside reset");
      cfg_load = 1'b0;
      access(3, 1'b0, 1'b0, 1'b0, 1, "R2 base still 3");

      // R6: extension raised after acknowledge changes nothing
      configure(1'b1, 1'b0, 1'b0, 1'b1, 1);
      access(1, 1'b0, 1'b0, 1'b1, 4, "R6 late extension ignored");

      // R8: burst re-handshake, base 2
      configure(1'b1, 1'b1, 1'b0, 1'b0, 2);
      for (int j = 0; j <= 3; j++) begin
         drive(1'b1, (j == 0), 1'b0, 1'b0, hsv(1, j >= 2), hsv(1, j >= 2), "R8 first beat");
      end
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 column enable negated");
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 column enable negated");
      for (int j = 0; j <= 3; j++) begin
         drive(1'b1, 1'b0, 1'b0, 1'b0, hsv(1, j >= 2), hsv(1, j >= 2), "R8 restart from column enable");
      end
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 end of burst");

      // R9: bursts disabled, column enable toggles ignored
      configure(1'b1, 1'b0, 1'b0, 1'b0, 1);
      for (int j = 0; j <= 2; j++) begin
         drive(1'b1, (j == 0), 1'b0, 1'b0, hsv(1, j >= 1), hsv(1, j >= 1), "R9 acknowledge");
      end
      for (int j = 0; j < 4; j++) begin
         drive(1'b1, 1'b0, (j % 2 == 0), 1'b0, 1'b0, 1'b0, "R9 toggle ignored");
      end
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 end");

      // R10: wait-type output, base 2, then with one extension edge
      configure(1'b0, 1'b0, 1'b0, 1'b0, 2);
      access(2, 1'b0, 1'b0, 1'b0, 2, "R10 wait mode base 2");
      access(3, 1'b0, 1'b1, 1'b1, 1, "R10 wait mode extended");
      configure(1'b0, 1'b0, 1'b0, 1'b0, 0);
      access(0, 1'b0, 1'b0, 1'b0, 1, "R10 wait mode base 0");

      while (q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule